// File: doc/BRIEF.md
# Ordered Write Buffer with Fence

This block sits between a core's load/store port and its data cache. A store is posted into a small buffer and accepted at once, so the core keeps running while memory is slow. The buffer hands its entries to the cache one at a time, oldest first, over a valid/ready handshake. Other agents therefore see the stores of this core in program order.

A load looks in the buffer before going to the cache. If one or more buffered stores target the same address, the newest of them supplies the data. Otherwise the data comes from the cache read port. A load does not wait for older stores to other addresses to drain, so it can appear ahead of them. A fence request is held off until the buffer is empty. This forces a full drain before any later instruction can proceed.

Top module: `tso_store_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it, `drn_valid` and `ld_valid` are 0 and the buffer is empty, so a fence is accepted at once.
- R2: The operation code on `req_kind` is 0 for a load, 1 for a store, 2 for a fence and 3 for no operation. A store is accepted (`req_ready`=1) in the cycle it is presented whenever fewer than DEPTH entries are buffered, even if the cache never takes a drain.
- R3: A store presented while DEPTH entries are buffered sees `req_ready`=0. It is accepted only after at least one entry has drained.
- R4: Entries leave on `drn_addr`/`drn_data` in the order the stores were accepted. At most one entry leaves per cycle, and only in a cycle where `drn_valid` and `drn_ready` are both 1. While `drn_ready` is 0, the offered entry is held stable.
- R5: A load is accepted in the cycle it is presented. In the next cycle `ld_valid`=1. If buffered stores match its address, `ld_hit`=1 and `ld_rdata` is the data of the newest matching store.
- R6: A load with no buffered match returns, one cycle later, the value presented on `cache_rd_data` for `cache_rd_addr`=`req_addr` in its issue cycle, with `ld_hit`=0.
- R7: A load is accepted even when older stores are still buffered, including when the buffer is full.
- R8: A fence sees `req_ready`=0 while any entry is buffered. It sees `req_ready`=1 in the first cycle in which the occupancy count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 0 load, 1 store, 2 fence, 3 no operation |
| req_addr | input | AW | Load or store address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle; 0 stalls the core |
| ld_valid | output | 1 | Load result valid (one cycle after issue) |
| ld_hit | output | 1 | Load result came from the buffer |
| ld_rdata | output | DW | Load result data |
| cache_rd_addr | output | AW | Cache read address for loads |
| cache_rd_data | input | DW | Cache read data, same cycle |
| drn_valid | output | 1 | An entry is offered to the cache |
| drn_ready | input | 1 | Cache takes the offered entry |
| drn_addr | output | AW | Address of the oldest entry |
| drn_data | output | DW | Data of the oldest entry |

## Verification
The bench builds the block with DEPTH=4, AW=3 and DW=8. With only eight addresses and four slots, the buffer often holds several stores to the same address, so loads pick among repeated matches and the newest-match rule is tested all the time. The buffer also fills quickly. The bench runs a directed phase where the cache refuses every drain, to reach the full state, and then a long random run with random cache stalls. This random run covers fences, full-buffer retries and the mix of buffered and cache loads.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_NOP   = 2'd3
  } sb_op_e;
endpackage

// File: rtl/sb_entry_ring.sv
// Circular storage for posted stores, with an age-ordered view for lookups.
module sb_entry_ring #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic [CW-1:0]             count,
  output logic [DEPTH-1:0]          age_vld,
  output logic [DEPTH-1:0][AW-1:0]  age_addr,
  output logic [DEPTH-1:0][DW-1:0]  age_data
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] head, tail;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // storage has no reset, written on one port
  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[tail] <= push_addr;
      data_mem[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= wrap_inc(tail);
      if (pop)  head <= wrap_inc(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // slot 0 is the oldest entry
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      logic [PW-1:0] idx;
      s = int'(head) + i;
      if (s >= DEPTH) s = s - DEPTH;
      idx = s[PW-1:0];
      age_addr[i] = addr_mem[idx];
      age_data[i] = data_mem[idx];
      age_vld[i]  = (i < int'(count));
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(count) < DEPTH));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
  // R4
  count_track_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sb_newest_match.sv
// Picks the newest valid entry whose address equals the lookup key.
module sb_newest_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic [DEPTH-1:0]          vld,
  input  logic [DEPTH-1:0][AW-1:0]  addr,
  input  logic [DEPTH-1:0][DW-1:0]  data,
  input  logic [AW-1:0]             key,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    // later slots are younger, so they overwrite earlier matches
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && addr[i] == key) begin
        hit      = 1'b1;
        hit_data = data[i];
      end
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          ld_valid,
  output logic          ld_hit,
  output logic [DW-1:0] ld_rdata,
  output logic [AW-1:0] cache_rd_addr,
  input  logic [DW-1:0] cache_rd_data,
  output logic          drn_valid,
  input  logic          drn_ready,
  output logic [AW-1:0] drn_addr,
  output logic [DW-1:0] drn_data
);
  import sb_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  sb_op_e                     op;
  logic [CW-1:0]              count;
  logic [DEPTH-1:0]           age_vld;
  logic [DEPTH-1:0][AW-1:0]   age_addr;
  logic [DEPTH-1:0][DW-1:0]   age_data;
  logic                       push, pop, is_load;
  logic                       fwd_hit;
  logic [DW-1:0]              fwd_data;
  logic                       empty, full;

  assign op    = sb_op_e'(req_kind);
  assign empty = (count == '0);
  assign full  = (int'(count) == DEPTH);

  always_comb begin
    case (op)
      OP_STORE: req_ready = !full;
      OP_FENCE: req_ready = empty;
      default:  req_ready = 1'b1;
    endcase
  end

  assign push    = req_valid && op == OP_STORE && !full;
  assign is_load = req_valid && op == OP_LOAD;

  assign drn_valid = !empty;
  assign drn_addr  = age_addr[0];
  assign drn_data  = age_data[0];
  assign pop       = drn_valid && drn_ready;

  assign cache_rd_addr = req_addr;

  sb_entry_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) ring_i (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(req_addr), .push_data(req_wdata),
    .pop(pop), .count(count),
    .age_vld(age_vld), .age_addr(age_addr), .age_data(age_data)
  );

  sb_newest_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) match_i (
    .vld(age_vld), .addr(age_addr), .data(age_data),
    .key(req_addr), .hit(fwd_hit), .hit_data(fwd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_hit   <= 1'b0;
      ld_rdata <= '0;
    end else begin
      ld_valid <= is_load;
      if (is_load) begin
        ld_hit   <= fwd_hit;
        ld_rdata <= fwd_hit ? fwd_data : cache_rd_data;
      end
    end
  end

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr) && $stable(drn_data)));
  // R8
  fence_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_FENCE && req_ready) |-> !drn_valid);
  // R5
  ld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(req_valid && op == OP_LOAD));
  // R7
  load_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_LOAD) |-> req_ready);
endmodule

// File: tb/tso_store_buffer_tb_top.sv
module tso_store_buffer_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int NADDR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready;
  logic          ld_valid, ld_hit;
  logic [DW-1:0] ld_rdata;
  logic [AW-1:0] cache_rd_addr;
  logic [DW-1:0] cache_rd_data;
  logic          drn_valid, drn_ready;
  logic [AW-1:0] drn_addr;
  logic [DW-1:0] drn_data;

  logic [DW-1:0] mem [NADDR];
  assign cache_rd_data = mem[cache_rd_addr];

  always #10 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .ld_valid(ld_valid), .ld_hit(ld_hit), .ld_rdata(ld_rdata),
    .cache_rd_addr(cache_rd_addr), .cache_rd_data(cache_rd_data),
    .drn_valid(drn_valid), .drn_ready(drn_ready),
    .drn_addr(drn_addr), .drn_data(drn_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit stall_all = 1'b0;

  // reference queue of buffered stores, index 0 oldest
  int qa [16];
  int qd [16];
  int qn = 0;

  bit exp_ldv = 1'b0;
  bit exp_hit = 1'b0;
  int exp_dat = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: drive, check outputs, then update the reference after the edge
  task automatic step(input bit v, input int kind, input int a, input int d, output bit acc);
    bit exp_rdy, do_pop, do_push;
    @(negedge clk);
    drn_ready = stall_all ? 1'b0 : ($urandom % 4 != 0);
    req_valid = v;
    req_kind  = kind[1:0];
    req_addr  = a[AW-1:0];
    req_wdata = d[DW-1:0];
    #1;
    // result of the previous cycle's load
    chk(ld_valid == exp_ldv, "R5", int'(ld_valid), int'(exp_ldv));
    if (exp_ldv) begin
      if (exp_hit) begin
        chk(ld_hit == 1'b1, "R5", int'(ld_hit), 1);
        chk(int'(ld_rdata) == exp_dat, "R5", int'(ld_rdata), exp_dat);
      end else begin
        chk(ld_hit == 1'b0, "R6", int'(ld_hit), 0);
        chk(int'(ld_rdata) == exp_dat, "R6", int'(ld_rdata), exp_dat);
      end
    end
    // drain port
    chk(drn_valid == (qn > 0), "R4", int'(drn_valid), int'(qn > 0));
    if (qn > 0) begin
      chk(int'(drn_addr) == qa[0], "R4", int'(drn_addr), qa[0]);
      chk(int'(drn_data) == qd[0], "R4", int'(drn_data), qd[0]);
    end
    // acceptance
    case (kind)
      1:       exp_rdy = (qn < DEPTH);
      2:       exp_rdy = (qn == 0);
      default: exp_rdy = 1'b1;
    endcase
    if (v) begin
      if (kind == 1)      chk(req_ready == exp_rdy, (qn < DEPTH) ? "R2" : "R3", int'(req_ready), int'(exp_rdy));
      else if (kind == 2) chk(req_ready == exp_rdy, "R8", int'(req_ready), int'(exp_rdy));
      else if (kind == 0) chk(req_ready == exp_rdy, "R7", int'(req_ready), int'(exp_rdy));
    end
    // expected load result for next cycle
    exp_ldv = v && kind == 0;
    if (exp_ldv) begin
      exp_hit = 1'b0;
      exp_dat = int'(mem[a]);
      for (int i = 0; i < qn; i++) begin
        if (qa[i] == a) begin
          exp_hit = 1'b1;
          exp_dat = qd[i];
        end
      end
    end
    do_pop  = (qn > 0) && drn_ready;
    do_push = v && kind == 1 && exp_rdy;
    acc = v && exp_rdy;
    @(posedge clk);
    #1;
    if (do_pop) begin
      mem[qa[0]] = qd[0][DW-1:0];
      for (int i = 0; i < 15; i++) begin
        qa[i] = qa[i+1];
        qd[i] = qd[i+1];
      end
      qn--;
    end
    if (do_push) begin
      qa[qn] = a;
      qd[qn] = d;
      qn++;
    end
  endtask

  task automatic issue(input int kind, input int a, input int d);
    bit acc;
    int tries = 0;
    do begin
      step(1'b1, kind, a, d, acc);
      tries++;
    end while (!acc && tries < 200);
    chk(acc, "R8", tries, 1);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit acc;
    for (int i = 0; i < NADDR; i++) mem[i] = DW'(i * 7 + 3);
    rst = 1'b1;
    req_valid = 1'b0; req_kind = 2'd3; req_addr = '0; req_wdata = '0; drn_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(drn_valid == 1'b0, "R1", int'(drn_valid), 0);
    chk(ld_valid == 1'b0, "R1", int'(ld_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b1; req_kind = 2'd2;
    #1;
    chk(drn_valid == 1'b0, "R1", int'(drn_valid), 0);
    chk(ld_valid == 1'b0, "R1", int'(ld_valid), 0);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    req_valid = 1'b0;

    // cache refuses all drains: fill, duplicate addresses, loads while full
    stall_all = 1'b1;
    step(1'b1, 1, 1, 8'h11, acc); chk(acc, "R2", int'(acc), 1);
    step(1'b1, 1, 2, 8'h22, acc); chk(acc, "R2", int'(acc), 1);
    step(1'b1, 1, 1, 8'h33, acc); chk(acc, "R2", int'(acc), 1);
    step(1'b1, 0, 1, 0, acc);   // newest of two matches
    step(1'b1, 1, 3, 8'h44, acc); chk(acc, "R2", int'(acc), 1);
    step(1'b1, 1, 5, 8'h55, acc); chk(!acc, "R3", int'(acc), 0);
    step(1'b1, 1, 5, 8'h55, acc); chk(!acc, "R3", int'(acc), 0);
    step(1'b1, 0, 5, 0, acc);   // miss while full
    step(1'b1, 0, 2, 0, acc);   // hit while full
    step(1'b1, 2, 0, 0, acc); chk(!acc, "R8", int'(acc), 0);
    step(1'b0, 3, 0, 0, acc);
    stall_all = 1'b0;
    issue(1, 5, 8'h55);
    issue(2, 0, 0);
    step(1'b1, 0, 1, 0, acc);   // after fence the value comes from the cache

    // random mix with random cache stalls
    for (int n = 0; n < 4000; n++) begin
      int r, k;
      r = $urandom % 10;
      k = (r < 4) ? 1 : (r < 8) ? 0 : (r < 9) ? 2 : 3;
      if (k == 3) step(1'b0, 3, 0, 0, acc);
      else issue(k, $urandom % NADDR, $urandom % 256);
    end
    step(1'b0, 3, 0, 0, acc);
    summary();
  end
endmodule